// File: doc/BRIEF.md
# Serial Flash Direct-Access Sequencer

This block sits between a memory-mapped bus and a byte-wide serial flash shifter. Each chip select owns a 128 MiB window. A bus access of 1 to 8 bytes, at any byte address inside a window, becomes one complete flash transaction. The block lowers that window's chip select and sends a command byte. It then sends 3, 4 or no address bytes, most significant first. A read adds a run of dummy transfers. The data bytes follow, least significant byte of the bus word first, and the chip select is then raised again.

The command, the address length and the dummy count come from two configuration words that are inputs to the block: one for reads and one for writes. The block samples the selected word when it accepts an access. The bus side is a plain request with a wait signal. The bus holds `bus_req` and its qualifiers steady while `bus_wait` is high. `bus_wait` drops for exactly one cycle, the completion cycle, and read data is valid in that cycle. The bus may then drop the request, or keep it high with new qualifiers to start the next access at once.

The shifter side is valid/ready, one byte out and one byte back per handshake. The shifter may hold `xfer_ready` low for any number of cycles. The block then holds `xfer_valid` and `xfer_tx` unchanged. `xfer_rx` is taken in the cycle of the handshake. A separate input reports that a chip select is already being driven by another agent. When it is high as an access is accepted, the block pulses `overlap_err` and carries out the access anyway.

Top module: `sfl_direct_seq`

## Requirements
- R1: Out of reset every `cs_n` bit is 1 and `xfer_valid` and `overlap_err` are 0. `bus_wait` is 0 while `bus_req` is 0.
- R2: An access to window k drives `cs_n[k]` low, and only that bit, from the cycle after acceptance through every transfer of the access. All `cs_n` bits are high again in the cycle where `bus_wait` is low.
- R3: The first transfer of a read carries `rd_cfg[7:0]`. The first transfer of a write carries `wr_cfg[7:0]`.
- R4: Bits 17:16 of the selected configuration set the address length. Value 0 sends `bus_addr` bits 23:0 as 3 bytes. Value 1 sends 4 bytes, the first being address bits 31:24 zero-extended. Values 2 and 3 send no address byte. Address bytes go most significant first.
- R5: After the address, a read sends (`rd_cfg[13:12]` × 8) >> `rd_cfg[9:8]` dummy transfers carrying 0x00.
- R6: A read then performs `bus_size` transfers carrying 0x00. The byte received in the i-th of them lands in `bus_rdata` byte i. Bytes at and above `bus_size` read as 0. `bus_size` is in the range 1 to 8.
- R7: A write sends `bus_wdata` bytes 0 up to `bus_size`-1 after the address, with no dummy transfers, whatever `rd_cfg` holds.
- R8: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid` stays high and `xfer_tx` holds its value. Each handshake moves exactly one byte.
- R9: `bus_wait` is high from the first cycle of a request until its last transfer completes, then low for exactly one cycle. `bus_rdata` is valid in that cycle.
- R10: If `user_cs_busy` is high when an access is accepted, `overlap_err` is high for exactly one cycle and the access proceeds with the same byte sequence.
- R11: With `rd_cfg` = 0x0300100B a read sends command 0x0B, 3 address bytes and 8 dummy transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_wait` falls |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | CS_W | Window (chip select) index |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_size | input | SIZE_W | Access length in bytes, 1..BUS_BYTES |
| bus_wdata | input | 8*BUS_BYTES | Write data, byte 0 sent first |
| bus_wait | output | 1 | Bus hold; low for one cycle at completion |
| bus_rdata | output | 8*BUS_BYTES | Read data, valid while `bus_wait` is low after a read |
| rd_cfg | input | 32 | Read configuration: command, address length, dummy fields |
| wr_cfg | input | 32 | Write configuration: command, address length |
| user_cs_busy | input | 1 | Another agent holds a chip select low |
| overlap_err | output | 1 | One-cycle pulse: access accepted while `user_cs_busy` |
| cs_n | output | NUM_CS | Active-low chip selects |
| xfer_valid | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ready | input | 1 | Shifter accepts the transfer |
| xfer_rx | input | 8 | Byte received in the handshake cycle |

## Verification
Random accesses vary the direction, window, size, address, address-length code, dummy width and access-width shift. Comparing each complete byte stream against a model separates the 3-byte, 4-byte and no-address paths. It also separates a write, which must skip dummies, from a read, which must insert them. Received bytes follow a position-dependent pattern, so a shifted or reordered read word shows up as a wrong `bus_rdata` value. Runs with heavy shifter back-pressure, the reset-value read configuration, the largest address and size, and the overlap flag check that stalls, defaults and the error pulse leave the byte sequence unchanged.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_FIN
  } seq_state_t;

  localparam int CFG_W   = 32;
  localparam int DUMMY_W = 5;
  localparam logic [31:0] RD_CFG_POR = 32'h0300_100B;
endpackage

// File: rtl/sfl_cfg_decode.sv
module sfl_cfg_decode
  import sfl_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg,
  input  logic               is_read,
  output logic [7:0]         cmd,
  output logic [2:0]         addr_len,
  output logic [DUMMY_W-1:0] dummy_n
);
  logic [DUMMY_W-1:0] dummy_bits;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg[CFG_W-1:18], cfg[15:14], cfg[11:10]};
  assign cmd = cfg[7:0];
  assign dummy_bits = {cfg[13:12], 3'b000};

  always_comb begin
    unique case (cfg[17:16])
      2'd0:    addr_len = 3'd3;
      2'd1:    addr_len = 3'd4;
      default: addr_len = 3'd0;
    endcase
    dummy_n = is_read ? (dummy_bits >> cfg[9:8]) : '0;
  end
endmodule

// File: rtl/sfl_cs_drive.sv
module sfl_cs_drive #(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic              rel_en,
  input  logic [CS_W-1:0]   sel_idx,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cs_n[g] <= 1'b1;
      else if (rel_en)                             cs_n[g] <= 1'b1;
      else if (sel_en && (sel_idx == CS_W'(g)))    cs_n[g] <= 1'b0;
    end
  end

  assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/sfl_rd_pack.sv
module sfl_rd_pack #(
  parameter int BUS_BYTES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_byte,
  output logic [8*BUS_BYTES-1:0] word
);
  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              word[8*g +: 8] <= '0;
      else if (clr)                            word[8*g +: 8] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))   word[8*g +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/sfl_direct_seq.sv
module sfl_direct_seq
  import sfl_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int ADDR_W    = 27,
  parameter int BUS_BYTES = 8,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int IDX_W    = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
  localparam int SIZE_W   = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [CS_W-1:0]        bus_sel,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [SIZE_W-1:0]      bus_size,
  input  logic [8*BUS_BYTES-1:0] bus_wdata,
  output logic                   bus_wait,
  output logic [8*BUS_BYTES-1:0] bus_rdata,
  input  logic [31:0]            rd_cfg,
  input  logic [31:0]            wr_cfg,
  input  logic                   user_cs_busy,
  output logic                   overlap_err,
  output logic [NUM_CS-1:0]      cs_n,
  output logic                   xfer_valid,
  output logic [7:0]             xfer_tx,
  input  logic                   xfer_ready,
  input  logic [7:0]             xfer_rx
);
  localparam int CNT_W = (DUMMY_W > SIZE_W) ? DUMMY_W : SIZE_W;

  seq_state_t state;
  logic [CNT_W-1:0]       cnt;
  logic                   we_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [SIZE_W-1:0]      size_q;
  logic [8*BUS_BYTES-1:0] wdata_q;
  logic [7:0]             cmd_q;
  logic [2:0]             alen_q;
  logic [DUMMY_W-1:0]     dn_q;

  logic [7:0]         dec_cmd;
  logic [2:0]         dec_alen;
  logic [DUMMY_W-1:0] dec_dn;
  logic               accept, hs, last_data;
  logic [31:0]        addr_ext;

  assign accept    = (state == ST_IDLE) && bus_req;
  assign hs        = xfer_valid && xfer_ready;
  assign last_data = (cnt == CNT_W'(size_q) - CNT_W'(1));
  assign addr_ext  = 32'(addr_q);
  assign bus_wait  = bus_req && (state != ST_FIN);
  assign xfer_valid = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DUMMY) || (state == ST_DATA);

  sfl_cfg_decode u_dec (
    .cfg      (bus_we ? wr_cfg : rd_cfg),
    .is_read  (!bus_we),
    .cmd      (dec_cmd),
    .addr_len (dec_alen),
    .dummy_n  (dec_dn)
  );

  sfl_cs_drive #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_en  (accept),
    .rel_en  ((state == ST_DATA) && hs && last_data),
    .sel_idx (bus_sel),
    .cs_n    (cs_n)
  );

  sfl_rd_pack #(.BUS_BYTES(BUS_BYTES), .IDX_W(IDX_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .wr_en   ((state == ST_DATA) && hs && !we_q),
    .wr_idx  (cnt[IDX_W-1:0]),
    .wr_byte (xfer_rx),
    .word    (bus_rdata)
  );

  always_comb begin
    unique case (state)
      ST_CMD:  xfer_tx = cmd_q;
      ST_ADDR: xfer_tx = addr_ext[8*cnt[1:0] +: 8];
      ST_DATA: xfer_tx = we_q ? wdata_q[8*cnt[IDX_W-1:0] +: 8] : 8'h00;
      default: xfer_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      size_q      <= '0;
      wdata_q     <= '0;
      cmd_q       <= '0;
      alen_q      <= '0;
      dn_q        <= '0;
      overlap_err <= 1'b0;
    end else begin
      overlap_err <= accept && user_cs_busy;
      unique case (state)
        ST_IDLE: if (bus_req) begin
          we_q    <= bus_we;
          addr_q  <= bus_addr;
          size_q  <= bus_size;
          wdata_q <= bus_wdata;
          cmd_q   <= dec_cmd;
          alen_q  <= dec_alen;
          dn_q    <= dec_dn;
          state   <= ST_CMD;
        end
        ST_CMD: if (hs) begin
          if (alen_q != 3'd0) begin
            state <= ST_ADDR;
            cnt   <= CNT_W'(alen_q) - CNT_W'(1);
          end else if (dn_q != '0) begin
            state <= ST_DUMMY;
            cnt   <= CNT_W'(dn_q) - CNT_W'(1);
          end else begin
            state <= ST_DATA;
            cnt   <= '0;
          end
        end
        ST_ADDR: if (hs) begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (dn_q != '0) begin
            state <= ST_DUMMY;
            cnt   <= CNT_W'(dn_q) - CNT_W'(1);
          end else begin
            state <= ST_DATA;
          end
        end
        ST_DUMMY: if (hs) begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else           state <= ST_DATA;
        end
        ST_DATA: if (hs) begin
          if (last_data) state <= ST_FIN;
          else           cnt   <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx));
  assert_cs_during_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !(&cs_n));
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wait |-> &cs_n);
  assert_wait_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wait |=> !bus_req || bus_wait);
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> !overlap_err);
  assert_size_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (bus_size != '0) && (bus_size <= SIZE_W'(BUS_BYTES)));
endmodule

// File: tb/sfl_direct_seq_tb.sv
module sfl_direct_seq_tb_top;
  localparam int NUM_CS = 2;
  localparam int ADDR_W = 27;
  localparam int BB     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              bus_req = 0, bus_we = 0;
  logic [0:0]        bus_sel = 0;
  logic [ADDR_W-1:0] bus_addr = 0;
  logic [3:0]        bus_size = 1;
  logic [8*BB-1:0]   bus_wdata = 0;
  logic              bus_wait;
  logic [8*BB-1:0]   bus_rdata;
  logic [31:0]       rd_cfg = 32'h0300_100B, wr_cfg = 32'h0300_0002;
  logic              user_cs_busy = 0;
  logic              overlap_err;
  logic [NUM_CS-1:0] cs_n;
  logic              xfer_valid;
  logic [7:0]        xfer_tx;
  logic              xfer_ready = 0;
  logic [7:0]        xfer_rx = 0;

  sfl_direct_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BUS_BYTES(BB)) dut_i (.*);

  int n_checks = 0, n_fail = 0;
  int stall_pct = 30;
  logic [7:0] salt = 0;
  logic [7:0] got_b [0:63];
  logic [NUM_CS-1:0] got_cs [0:63];
  int got_n = 0, err_seen = 0;
  logic [7:0] exp_b [0:63];
  int exp_n = 0, rd_start = 0;

  function automatic logic [7:0] rx_of(int n, logic [7:0] s);
    return 8'(n * 29 + 8'h5A) ^ s;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // shifter model: ready chosen at falling edge, handshake logged for the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (overlap_err) err_seen++;
      xfer_ready = (($urandom % 100) >= 32'(stall_pct));
      xfer_rx    = rx_of(got_n, salt);
      if (xfer_valid && xfer_ready && got_n < 64) begin
        got_b[got_n]  = xfer_tx;
        got_cs[got_n] = cs_n;
        got_n++;
      end
    end
  end

  task automatic build_exp(bit we, logic [ADDR_W-1:0] a, int sz, logic [8*BB-1:0] wd,
                           logic [31:0] rc, logic [31:0] wc);
    logic [31:0] cfg = we ? wc : rc;
    logic [31:0] ax = 32'(a);
    int alen = (cfg[17:16] == 0) ? 3 : (cfg[17:16] == 1) ? 4 : 0;
    int dn = we ? 0 : ((int'(cfg[13:12]) * 8) >> cfg[9:8]);
    exp_n = 0;
    exp_b[exp_n++] = cfg[7:0];
    for (int i = alen - 1; i >= 0; i--) exp_b[exp_n++] = ax[8*i +: 8];
    for (int i = 0; i < dn; i++) exp_b[exp_n++] = 8'h00;
    rd_start = exp_n;
    for (int i = 0; i < sz; i++) exp_b[exp_n++] = we ? wd[8*i +: 8] : 8'h00;
  endtask

  task automatic run_access(bit we, logic [0:0] sel, logic [ADDR_W-1:0] a, int sz,
                            logic [8*BB-1:0] wd, logic [31:0] rc, logic [31:0] wc,
                            bit busy, string rq);
    logic [8*BB-1:0] exp_rd;
    int bad = 0, bad_cs = 0;
    @(negedge clk);
    build_exp(we, a, sz, wd, rc, wc);
    salt = 8'($urandom);
    got_n = 0; err_seen = 0;
    rd_cfg = rc; wr_cfg = wc; user_cs_busy = busy;
    bus_we = we; bus_sel = sel; bus_addr = a; bus_size = 4'(sz); bus_wdata = wd;
    bus_req = 1;
    do @(negedge clk); while (bus_wait);
    // completion cycle
    check(&cs_n, "R2", "cs released at completion", 64'(cs_n), 64'(2'b11));
    exp_rd = '0;
    if (!we) for (int i = 0; i < sz; i++) exp_rd[8*i +: 8] = rx_of(rd_start + i, salt);
    if (!we) check(bus_rdata == exp_rd, "R6", "read word", bus_rdata, exp_rd);
    bus_req = 0; user_cs_busy = 0;
    check(got_n == exp_n, rq, "transfer count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (got_b[i] != exp_b[i] && bad == 0)
        check(0, rq, $sformatf("byte %0d", i), 64'(got_b[i]), 64'(exp_b[i]));
      if (got_b[i] != exp_b[i]) bad++;
      if (got_cs[i] != ~(2'b01 << sel)) bad_cs++;
    end
    if (bad == 0) check(1, rq, "bytes", 0, 0);
    check(bad_cs == 0, "R2", "cs during transfers", 64'(bad_cs), 0);
    check(err_seen == (busy ? 1 : 0), "R10", "overlap pulses", 64'(err_seen), 64'(busy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 2'b11, "R1", "cs_n in reset", 64'(cs_n), 64'(3));
    check(!xfer_valid && !overlap_err && !bus_wait, "R1", "idle outputs",
          64'({xfer_valid, overlap_err, bus_wait}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(cs_n == 2'b11 && !xfer_valid, "R1", "after reset release",
          64'({cs_n, xfer_valid}), 64'(6));

    // directed corners
    run_access(0, 0, 27'h012_3456, 4, '0, 32'h0300_100B, 32'h0, 0, "R11");
    run_access(0, 1, 27'h7FF_FFFF, 8, '0, 32'h0001_3003, 32'h0, 0, "R4");
    run_access(1, 1, 27'h7AB_CDEF, 8, 64'h8877_6655_4433_2211, 32'h0000_3000,
               32'h0001_0012, 0, "R7");
    run_access(0, 0, 27'h000_0001, 1, '0, 32'h0002_0066, 32'h0, 0, "R4");
    run_access(0, 1, 27'h055_AA55, 3, '0, 32'h0000_2344, 32'h0, 1, "R10");
    run_access(1, 0, 27'h001_0203, 2, 64'hBEEF, 32'h0, 32'h0003_0077, 0, "R3");
    stall_pct = 90;
    run_access(0, 1, 27'h123_4567, 5, '0, 32'h0000_1100, 32'h0, 0, "R8");
    run_access(1, 0, 27'h765_4321, 6, 64'h0102_0304_0506_0708, 32'h0,
               32'h0000_0022, 0, "R8");
    stall_pct = 30;

    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [31:0] rc = $urandom, wc = $urandom;
      bit we = $urandom % 2;
      run_access(we, 1'($urandom), 27'($urandom), 1 + ($urandom % 8),
                 {$urandom, $urandom}, rc, wc, ($urandom % 8) == 0,
                 we ? "R7" : "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule